// File: doc/BRIEF.md
# Line-Locked Clamp Pulse Generator

This block makes clamp pulses for a video front end, timed from a horizontal sync input. An 8-bit time base runs freely and restarts at every rising sync edge. Two early clamp outputs rise together on that edge and fall once the time base reaches a programmable early width. A late clamp output is placed inside the following line at an offset taken from the sync pulse itself. The time base is sampled when sync falls, and the late pulse starts when the time base returns to that sampled value. It then stays high for a programmable number of clocks.

The sync input is asynchronous. It passes through a synchronizer before any edge is acted on. Software or a neighbouring block loads the two width registers through simple write strobes. All state changes on the system clock, so the late pulse has an exact width in clocks. Its phase, and the end of the early pulses, can shift by up to one clock against the raw sync edge.

Top module: `clamp_pulse_gen`

## Requirements
- R1: While `rst_n` is low, all three clamp outputs are low, and the time base, the sampled offset and both width registers are zero.
- R2: The sync input passes through a two-stage synchronizer and an edge detector. If `sync_in` is first sampled high at clock edge k, the early clamps rise at edge k+2, so they are visible after the third edge that sees it high.
- R3: The early clamps rise on a detected rising sync edge, and the time base restarts at zero on that edge. They fall on the clock after the time base equals the early width W, so an undisturbed early pulse lasts W+1 clocks.
- R4: `clamp_early_a` and `clamp_early_b` are equal in every cycle.
- R5: A write strobe loads its width register at the next clock edge. The new value governs comparisons from the following cycle on.
- R6: With no sync edge, the time base counts up by one each clock and wraps from 255 to 0, so its matches repeat every 256 clocks.
- R7: On a detected falling sync edge, the current time base value is stored as the late offset. For a sync pulse sampled high on H clocks, the stored offset is H-1, and in the next line the late clamp rises H clocks after the early clamps rise.
- R8: The late clamp rises on the clock after the time base equals the stored offset. It falls on the clock after the time base equals offset plus late width, which gives a pulse of exactly the late width in clocks. With a late width of zero, no late pulse appears, because the fall match wins over the rise match.
- R9: Offset plus late width is formed at 9 bits. A sum above 255 never matches, so the late clamp stays high until the next rising sync edge.
- R10: A detected rising sync edge forces the late clamp low and sets the early clamps in that cycle. It takes priority over any width or offset match in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_in | input | 1 | Horizontal sync, asynchronous to clk |
| early_width_wr | input | 1 | Load strobe for the early width register |
| early_width_data | input | 8 | Early width value |
| late_width_wr | input | 1 | Load strobe for the late width register |
| late_width_data | input | 8 | Late width value in clocks |
| clamp_early_a | output | 1 | First early clamp pulse |
| clamp_early_b | output | 1 | Second early clamp pulse |
| clamp_late | output | 1 | Late clamp pulse |

## Verification
A wrong time base shows up at once as a wrong early pulse length. It also moves the late pulse within the next line, so an error becomes visible within one line of sync. A bad sampled offset or sum shows as a late pulse at the wrong distance from the early rise, with a wrong length, or one that never ends. Such a pulse is visible from the next rising sync edge. A wrong edge priority shows in the cycle after the colliding edge, as an early clamp that drops or a late clamp that survives.

// File: rtl/clamp_pkg.sv
package clamp_pkg;

    // Registered state of the three clamp outputs.
    typedef struct packed {
        logic early_a;
        logic early_b;
        logic late;
    } clamp_out_t;

    // Edge events delivered by the synchronizer.
    typedef struct packed {
        logic rise;
        logic fall;
    } sync_evt_t;

endpackage

// File: rtl/clamp_sync_edge.sv
module clamp_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sync_in,
    output clamp_pkg::sync_evt_t  evt
);
    localparam int HIST_W = STAGES + 1;

    typedef struct packed {
        logic [HIST_W-1:0] sh;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[HIST_W-2:0], sync_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Bit STAGES-1 is the synchronized level, and bit STAGES holds its previous value.
    always_comb begin
        evt.rise = st_q.sh[STAGES-1] & ~st_q.sh[STAGES];
        evt.fall = ~st_q.sh[STAGES-1] & st_q.sh[STAGES];
    end

endmodule

// File: rtl/clamp_timebase.sv
module clamp_timebase #(
    parameter int CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  clamp_pkg::sync_evt_t evt,
    input  logic                 early_width_wr,
    input  logic [CNT_W-1:0]     early_width_data,
    input  logic                 late_width_wr,
    input  logic [CNT_W-1:0]     late_width_data,
    output logic [CNT_W-1:0]     cnt,
    output logic [CNT_W-1:0]     offset,
    output logic [CNT_W-1:0]     early_width,
    output logic [CNT_W-1:0]     late_width
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] offset;
        logic [CNT_W-1:0] ew;
        logic [CNT_W-1:0] lw;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Free-running count, restarted by a rising sync edge.
        if (evt.rise) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + ONE;
        end
        // The falling sync edge fixes the late offset within the line.
        if (evt.fall) begin
            st_d.offset = st_q.cnt;
        end
        if (early_width_wr) begin
            st_d.ew = early_width_data;
        end
        if (late_width_wr) begin
            st_d.lw = late_width_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt         = st_q.cnt;
    assign offset      = st_q.offset;
    assign early_width = st_q.ew;
    assign late_width  = st_q.lw;

endmodule

// File: rtl/clamp_pulse_ctrl.sv
module clamp_pulse_ctrl #(
    parameter int CNT_W   = 8,
    parameter int N_EARLY = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  clamp_pkg::sync_evt_t evt,
    input  logic [CNT_W-1:0]     cnt,
    input  logic [CNT_W-1:0]     offset,
    input  logic [CNT_W-1:0]     early_width,
    input  logic [CNT_W-1:0]     late_width,
    output logic [N_EARLY-1:0]   early,
    output logic                 late
);
    localparam int SUM_W = CNT_W + 1;

    typedef struct packed {
        logic [N_EARLY-1:0] early;
        logic               late;
    } state_t;

    state_t st_d, st_q;

    logic [SUM_W-1:0] late_end;
    logic             hit_early_end;
    logic             hit_late_start;
    logic             hit_late_end;

    always_comb begin
        late_end       = {1'b0, offset} + {1'b0, late_width};
        hit_early_end  = (cnt == early_width);
        hit_late_start = (cnt == offset);
        hit_late_end   = ({1'b0, cnt} == late_end);
    end

    always_comb begin
        st_d = st_q;
        if (evt.rise) begin
            // A sync edge outranks every match in the same cycle.
            st_d.early = '1;
            st_d.late  = 1'b0;
        end else begin
            if (hit_early_end) begin
                st_d.early = '0;
            end
            if (hit_late_end) begin
                st_d.late = 1'b0;
            end else if (hit_late_start) begin
                st_d.late = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign early = st_q.early;
    assign late  = st_q.late;

endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic             early_width_wr,
    input  logic [CNT_W-1:0] early_width_data,
    input  logic             late_width_wr,
    input  logic [CNT_W-1:0] late_width_data,
    output logic             clamp_early_a,
    output logic             clamp_early_b,
    output logic             clamp_late
);
    localparam int N_EARLY = 2;

    clamp_pkg::sync_evt_t evt;
    clamp_pkg::clamp_out_t outs;
    logic [CNT_W-1:0]     cnt;
    logic [CNT_W-1:0]     offset;
    logic [CNT_W-1:0]     early_width;
    logic [CNT_W-1:0]     late_width;
    logic [N_EARLY-1:0]   early;
    logic                 late;

    clamp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_in),
        .evt     (evt)
    );

    clamp_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk              (clk),
        .rst_n            (rst_n),
        .evt              (evt),
        .early_width_wr   (early_width_wr),
        .early_width_data (early_width_data),
        .late_width_wr    (late_width_wr),
        .late_width_data  (late_width_data),
        .cnt              (cnt),
        .offset           (offset),
        .early_width      (early_width),
        .late_width       (late_width)
    );

    clamp_pulse_ctrl #(.CNT_W(CNT_W), .N_EARLY(N_EARLY)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (evt),
        .cnt         (cnt),
        .offset      (offset),
        .early_width (early_width),
        .late_width  (late_width),
        .early       (early),
        .late        (late)
    );

    always_comb begin
        outs.early_a = early[0];
        outs.early_b = early[1];
        outs.late    = late;
    end

    assign clamp_early_a = outs.early_a;
    assign clamp_early_b = outs.early_b;
    assign clamp_late    = outs.late;

endmodule

// File: rtl/clamp_pulse_checker.sv
module clamp_pulse_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rise,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] offset,
    input logic [CNT_W-1:0] early_width,
    input logic             clamp_early_a,
    input logic             clamp_early_b,
    input logic             clamp_late
);
    assert_early_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_early_a == clamp_early_b);

    assert_edge_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (clamp_early_a && !clamp_late));

    assert_early_rise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clamp_early_a) |-> $past(rise));

    assert_early_fall_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clamp_early_a) |-> ($past(cnt == early_width) && !$past(rise)));

    assert_late_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clamp_late) |-> ($past(cnt == offset) && !$past(rise)));

    assert_timebase_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    assert_timebase_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (cnt == '0));

endmodule

bind clamp_pulse_gen clamp_pulse_checker #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rise          (evt.rise),
    .cnt           (cnt),
    .offset        (offset),
    .early_width   (early_width),
    .clamp_early_a (clamp_early_a),
    .clamp_early_b (clamp_early_b),
    .clamp_late    (clamp_late)
);

// File: tb/test_clamp_pulse_gen.sv
`timescale 1ns/1ps
module test_clamp_pulse_gen;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sync_in = 1'b0;
    logic         ew_wr = 1'b0;
    logic [W-1:0] ew_data = '0;
    logic         lw_wr = 1'b0;
    logic [W-1:0] lw_data = '0;
    logic         ca, cb, cl;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    clamp_pulse_gen i_clamp_pulse_gen (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in),
        .early_width_wr(ew_wr), .early_width_data(ew_data),
        .late_width_wr(lw_wr), .late_width_data(lw_data),
        .clamp_early_a(ca), .clamp_early_b(cb), .clamp_late(cl)
    );

    // Reference model built from the requirements.
    logic [2:0]   m_s;
    logic [W-1:0] m_cnt, m_off, m_ew, m_lw;
    logic         m_a, m_c;
    wire          m_rise = m_s[1] & ~m_s[2];
    wire          m_fall = ~m_s[1] & m_s[2];
    wire [W:0]    m_end  = {1'b0, m_off} + {1'b0, m_lw};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s <= '0; m_cnt <= '0; m_off <= '0; m_ew <= '0; m_lw <= '0;
            m_a <= 1'b0; m_c <= 1'b0;
        end else begin
            m_s   <= {m_s[1:0], sync_in};
            m_cnt <= m_rise ? '0 : m_cnt + 1'b1;
            if (m_fall) m_off <= m_cnt;
            if (ew_wr) m_ew <= ew_data;
            if (lw_wr) m_lw <= lw_data;
            if (m_rise) begin
                m_a <= 1'b1; m_c <= 1'b0;
            end else begin
                if (m_cnt == m_ew) m_a <= 1'b0;
                if ({1'b0, m_cnt} == m_end) m_c <= 1'b0;
                else if (m_cnt == m_off) m_c <= 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(ca == m_a, "R3 early_a", int'(ca), int'(m_a));
            chk(cb == m_a, "R4 early_b", int'(cb), int'(m_a));
            chk(cl == m_c, "R8 late", int'(cl), int'(m_c));
        end
    end

    // Pulse measurement monitor.
    int cyc = 0, a_run = 0, c_run = 0, last_a_len = -1, last_c_len = -1;
    int a_rise_cyc = 0, c_rise_cyc = 0, c_period = 0, c_rises = 0;
    logic pa = 1'b0, pc = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (ca) a_run++;
        else if (pa) begin last_a_len = a_run; a_run = 0; end
        if (cl) c_run++;
        else if (pc) begin last_c_len = c_run; c_run = 0; end
        if (ca && !pa) a_rise_cyc = cyc;
        if (cl && !pc) begin
            c_period = cyc - c_rise_cyc;
            c_rise_cyc = cyc;
            c_rises++;
        end
        pa = ca; pc = cl;
    end

    task automatic line(input int h, input int p);
        for (int i = 0; i < p; i++) begin
            @(negedge clk);
            sync_in = (i < h);
        end
    endtask

    task automatic wr_early(input int v);
        @(negedge clk); ew_wr = 1'b1; ew_data = W'(v);
        @(negedge clk); ew_wr = 1'b0;
    endtask

    task automatic wr_late(input int v);
        @(negedge clk); lw_wr = 1'b1; lw_data = W'(v);
        @(negedge clk); lw_wr = 1'b0;
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(negedge clk);
        chk({ca, cb, cl} == 3'b000, "R1 reset outputs", int'({ca, cb, cl}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({ca, cb, cl} == 3'b000, "R1 after release", int'({ca, cb, cl}), 0);

        // R5: widths loaded by strobe
        wr_early(5);
        wr_late(3);
        repeat (5) @(negedge clk);

        // R2: three-edge latency
        sync_in = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(ca == 1'b0, "R2 latency edge1", int'(ca), 0);
        @(posedge clk); @(negedge clk);
        chk(ca == 1'b0, "R2 latency edge2", int'(ca), 0);
        @(posedge clk); @(negedge clk);
        chk(ca == 1'b1, "R2 latency edge3", int'(ca), 1);
        line(0, 36);
        line(4, 40);
        line(4, 40);
        chk(last_a_len == 6, "R3 early length W+1", last_a_len, 6);
        chk(c_rise_cyc - a_rise_cyc == 4, "R7 late offset H", c_rise_cyc - a_rise_cyc, 4);
        chk(last_c_len == 3, "R8 late width", last_c_len, 3);

        // R9: 9-bit sum past 255 holds until next sync edge
        wr_late(100);
        line(200, 240);
        line(200, 240);
        line(200, 240);
        line(4, 40);
        chk(last_c_len == 40, "R9 sum overflow hold", last_c_len, 40);

        // R10: sync edge cuts a long late pulse
        wr_late(50);
        line(4, 30);
        line(4, 30);
        line(4, 30);
        chk(last_c_len == 26, "R10 edge cut", last_c_len, 26);
        line(4, 30);

        // R8: zero late width gives no pulse
        wr_late(0);
        line(4, 30);
        c_rises = 0;
        line(4, 30);
        line(4, 30);
        line(4, 30);
        chk(c_rises == 0, "R8 zero width no pulse", c_rises, 0);

        // R6: wrap of the free-running count without sync
        wr_late(3);
        line(4, 40);
        line(4, 40);
        line(0, 700);
        chk(c_period == 256, "R6 wrap period", c_period, 256);
        chk(last_c_len == 3, "R6 late width after wrap", last_c_len, 3);

        // Random lines and width writes, checked by the model each cycle
        for (int n = 0; n < 60; n++) begin
            int h, p;
            if ($urandom_range(0, 2) == 0) wr_early(int'($urandom_range(0, 30)));
            if ($urandom_range(0, 2) == 0) wr_late(int'($urandom_range(0, 120)));
            h = int'($urandom_range(1, 12));
            p = int'($urandom_range(h + 20, 250));
            line(h, p);
        end
        line(0, 300);

        summary();
        $finish;
    end
endmodule